// File: doc/BRIEF.md
# Majority Decoder Early-Exit Detection Controller

This block drives a serial majority-logic decoder for a 73-bit cyclic codeword and decides, after the first three decode steps, whether the word needs the full decode. A read word is loaded on a start strobe. On every step the externally computed check-sum vector for the bit at the last tap comes in. The word register rotates by one position and that bit is inverted when most check sums are 1.

The controller ORs the check sums of each of the first three steps into a three-deep history. At the third step a second OR over that history gives the verdict. If no check sum was ever set, the word is declared clean. The controller asserts `finish` and presents the word, so a clean read costs three cycles instead of seventy-three. Any set check sum raises `err_det` and the decode runs to its full length before `finish`. The output word is forced to zero whenever `finish` is low.

Top module: `mld_early_exit`

## Requirements
- R1: While and right after reset, `finish` and `err_det` are 0 and `word_out` is all zeros.
- R2: `start` is accepted only when no decode is in progress, meaning after reset or while `finish` is high. An accepted start loads `word_in`. A `start` during a decode has no effect on that decode's timing or result.
- R3: If `chk` is all zeros in each of the three clock cycles after the accepting edge, `finish` goes high after the third of those edges, exactly 3 cycles after acceptance. It is never high earlier.
- R4: On the early-exit path, `word_out` equals the word that was loaded, in its original bit order.
- R5: If `chk` is nonzero in any of the three cycles after acceptance, `err_det` is high from 3 through 72 cycles after acceptance. `finish` then rises exactly 73 cycles after acceptance.
- R6: On the full path, decode cycle k (k = 1..73 counted from the accepting edge) handles bit 73-k of the loaded word. That bit is inverted in `word_out` when at least 5 of the 9 `chk` bits are 1 in that cycle. With 4 or fewer it is kept.
- R7: `finish` and `err_det` are never high together, and `err_det` drops when `finish` rises.
- R8: `word_out` is all zeros whenever `finish` is low.
- R9: `finish` and `word_out` hold until the next accepted start. `finish` drops on the accepting edge.
- R10: Each accepted start clears the step count and the three-cycle history. A word that follows a full decode exits early when its own first three cycles are clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decode of `word_in` |
| word_in | input | 73 | Codeword read from memory |
| chk | input | 9 | Check sums for the bit at the last tap in this cycle |
| finish | output | 1 | Decode complete; `word_out` valid |
| err_det | output | 1 | Word is taking the full decode path |
| word_out | output | 73 | Decoded word, zero unless `finish` |

## Verification
The hardest cases sit at the edges of the three-cycle window. A single nonzero check sum may land in only the first or only the third cycle. A word may also carry errors whose bits are decoded only after the window closes; these must still exit early and leave the word untouched. The stimulus drives `chk` per cycle from a flip mask and a single injected noise vector. This places set check sums at exact decode cycles, covers the 4-versus-5 majority boundary and a correction in the last cycle, and adds a stray start in mid-decode.

// File: rtl/mld_ee_pkg.sv
package mld_ee_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCAN,
        PH_FULL,
        PH_DONE_FAST,
        PH_DONE_FULL
    } phase_e;

    typedef struct packed {
        logic at_last;
        logic clean;
    } scan_verdict_t;

    function automatic int unsigned ones64(input logic [63:0] v, input int unsigned w);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < w && v[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/mld_ee_scan.sv
module mld_ee_scan
    import mld_ee_pkg::*;
#(
    parameter int unsigned DET = 3,
    parameter int unsigned J   = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [J-1:0]  chk,
    output scan_verdict_t verdict
);
    localparam int unsigned CW = $clog2(DET + 1);

    logic [CW-1:0]  cnt;
    logic [DET-1:0] hist;
    logic [DET-1:0] hist_nxt;
    logic           any_now;

    assign any_now = |chk;

    generate
        if (DET > 1) begin : g_deep
            assign hist_nxt = {hist[DET-2:0], any_now};
        end else begin : g_single
            assign hist_nxt = any_now;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            hist <= '0;
        end else if (en) begin
            hist <= hist_nxt;
            if (cnt != CW'(DET)) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        verdict.at_last = en && (cnt == CW'(DET - 1));
        verdict.clean   = ~|hist_nxt;
    end
endmodule

// File: rtl/mld_ee_rot.sv
module mld_ee_rot
    import mld_ee_pkg::*;
#(
    parameter int unsigned N = 73,
    parameter int unsigned J = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] word_in,
    input  logic         step,
    input  logic [J-1:0] chk,
    output logic [N-1:0] word_q
);
    logic maj;

    always_comb maj = ones64(64'(chk), J) > (J / 2);

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= word_in;
        else if (step) word_q <= {word_q[N-2:0], word_q[N-1] ^ maj};
    end
endmodule

// File: rtl/mld_ee_len.sv
module mld_ee_len #(
    parameter int unsigned N = 73
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int unsigned CW = $clog2(N);

    logic [CW-1:0] cnt;

    assign last = step && (cnt == CW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (step && !last)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mld_early_exit.sv
module mld_early_exit
    import mld_ee_pkg::*;
#(
    parameter int unsigned N   = 73,
    parameter int unsigned J   = 9,
    parameter int unsigned DET = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] word_in,
    input  logic [J-1:0] chk,
    output logic         finish,
    output logic         err_det,
    output logic [N-1:0] word_out
);
    phase_e        phase_q, phase_d;
    scan_verdict_t verdict;
    logic          accept, scan_en, step, last_step;
    logic [N-1:0]  word_q, word_unrot;

    assign accept  = start && (phase_q == PH_IDLE || phase_q == PH_DONE_FAST ||
                               phase_q == PH_DONE_FULL);
    assign scan_en = (phase_q == PH_SCAN);
    assign step    = scan_en || (phase_q == PH_FULL);

    mld_ee_scan #(.DET(DET), .J(J)) u_scan (
        .clk(clk), .rst(rst), .clr(accept), .en(scan_en), .chk(chk), .verdict(verdict)
    );

    mld_ee_rot #(.N(N), .J(J)) u_rot (
        .clk(clk), .rst(rst), .load(accept), .word_in(word_in),
        .step(step), .chk(chk), .word_q(word_q)
    );

    mld_ee_len #(.N(N)) u_len (
        .clk(clk), .rst(rst), .clr(accept), .step(step), .last(last_step)
    );

    always_comb begin
        phase_d = phase_q;
        if (accept) begin
            phase_d = PH_SCAN;
        end else begin
            case (phase_q)
                PH_SCAN: if (verdict.at_last)
                             phase_d = verdict.clean ? PH_DONE_FAST : PH_FULL;
                PH_FULL: if (last_step) phase_d = PH_DONE_FULL;
                default: phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign word_unrot = {word_q[DET-1:0], word_q[N-1:DET]};

    always_comb begin
        finish   = (phase_q == PH_DONE_FAST) || (phase_q == PH_DONE_FULL);
        err_det  = (phase_q == PH_FULL);
        word_out = '0;
        if (phase_q == PH_DONE_FAST)      word_out = word_unrot;
        else if (phase_q == PH_DONE_FULL) word_out = word_q;
    end
endmodule

// File: rtl/mld_early_exit_chk.sv
module mld_early_exit_chk #(
    parameter int unsigned N   = 73,
    parameter int unsigned DET = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         finish,
    input logic         err_det,
    input logic [N-1:0] word_out
);
    localparam int unsigned CW = $clog2(N + 2);

    logic          live;
    logic [CW-1:0] c;
    logic          acc_c;

    assign acc_c = start && (finish || !live);

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 1'b0;
            c    <= '0;
        end else if (acc_c) begin
            live <= 1'b1;
            c    <= '0;
        end else if (live && c != CW'(N + 1)) begin
            c <= c + 1'b1;
        end
    end

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(finish && err_det));

    a_r8_zero_gate: assert property (@(posedge clk) disable iff (rst)
        !finish |-> (word_out == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (finish && !start) |=> (finish && $stable(word_out)));

    a_r5_err_persist: assert property (@(posedge clk) disable iff (rst)
        err_det |=> (err_det || finish));

    a_r3_exit_time: assert property (@(posedge clk) disable iff (rst)
        $rose(finish) |-> (c == CW'(DET) || c == CW'(N)));

    a_r5_full_len: assert property (@(posedge clk) disable iff (rst)
        ($rose(finish) && $past(err_det)) |-> (c == CW'(N)));

    a_r3_quiet_window: assert property (@(posedge clk) disable iff (rst)
        (live && c < CW'(DET)) |-> (!finish && !err_det));

    always_comb begin
        if (!rst) a_r1_exclusive_imm: assert (!(finish && err_det));
    end
endmodule

bind mld_early_exit mld_early_exit_chk #(.N(N), .DET(DET)) u_chk (
    .clk(clk), .rst(rst), .start(start), .finish(finish),
    .err_det(err_det), .word_out(word_out)
);

// File: tb/sim_mld_early_exit.sv
`timescale 1ns/1ps
module sim_mld_early_exit;
    localparam int N   = 73;
    localparam int J   = 9;
    localparam int DET = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] word_in = '0;
    logic [J-1:0] chk = '0;
    logic         finish, err_det;
    logic [N-1:0] word_out;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] q_word[$];
    int           q_lat[$];
    bit           q_fast[$];
    string        q_tag[$];

    bit active = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    mld_early_exit #(.N(N), .J(J), .DET(DET)) u0 (
        .clk(clk), .rst(rst), .start(start), .word_in(word_in), .chk(chk),
        .finish(finish), .err_det(err_det), .word_out(word_out)
    );

    task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [J-1:0] chk_for(input int k, input logic [N-1:0] m,
                                             input int nk, input logic [J-1:0] nv);
        if (k >= 1 && k <= N && m[N-k]) return 9'b000011111;
        if (k == nk) return nv;
        return '0;
    endfunction

    // driver: pushes expected result, then feeds per-cycle check sums
    task automatic run_word(input logic [N-1:0] w, input logic [N-1:0] m,
                            input int nk, input logic [J-1:0] nv,
                            input int late_k, input string tag);
        bit           fast;
        logic [N-1:0] e_w, one;
        int           k;
        fast = (m[N-1 -: DET] == '0) && !(nk >= 1 && nk <= DET && nv != '0);
        one = '0;
        if (nk >= 1 && nk <= N && $countones(nv) > J / 2) one[N-nk] = 1'b1;
        e_w = fast ? w : (w ^ m ^ one);
        q_word.push_back(e_w);
        q_lat.push_back(fast ? DET : N);
        q_fast.push_back(fast);
        q_tag.push_back(tag);
        @(negedge clk);
        word_in = w;
        start   = 1'b1;
        chk     = '0;
        cyc     = -1;
        active  = 1;
        k = 1;
        while (active) begin
            @(negedge clk);
            start = (k == late_k);
            if (start) word_in = ~w;
            chk = chk_for(k, m, nk, nv);
            k++;
        end
        start = 1'b0;
        chk   = '0;
        repeat (2) @(negedge clk);
        check(finish == 1'b1 && word_out == e_w, {"R9 hold ", tag}, word_out, e_w);
    endtask

    // monitor: pops expectations and compares at each cycle of a decode
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (active && q_lat.size() > 0) begin
                int           lat, e_lat;
                bit           fast, e_err;
                logic [N-1:0] e_w;
                string        tag;
                cyc++;
                lat   = cyc;
                e_lat = q_lat[0];
                fast  = q_fast[0];
                e_w   = q_word[0];
                tag   = q_tag[0];
                e_err = !fast && lat >= DET && lat < N;
                check(err_det == e_err, {"R5 err_det ", tag}, N'(err_det), N'(e_err));
                if (lat < e_lat) begin
                    check(!finish, {"R3 early finish ", tag}, N'(finish), '0);
                    check(word_out == '0, {"R8 gated ", tag}, word_out, '0);
                end else begin
                    check(finish, {fast ? "R3 finish " : "R5 finish ", tag}, N'(finish), N'(1));
                    check(word_out == e_w, {fast ? "R4 word " : "R6 word ", tag}, word_out, e_w);
                    check(!err_det, {"R7 excl ", tag}, N'(err_det), '0);
                    void'(q_lat.pop_front());
                    void'(q_fast.pop_front());
                    void'(q_word.pop_front());
                    void'(q_tag.pop_front());
                    active = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] wa, wb, m;
        wa = {9'h1A5, 64'hDEADBEEF_0BADF00D};
        wb = {9'h05A, 64'h0123_4567_89AB_CDEF};
        repeat (4) @(negedge clk);
        check(!finish && !err_det && word_out == '0, "R1 in reset", word_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!finish && !err_det && word_out == '0, "R1 after reset", word_out, '0);

        run_word(wa, '0, 0, '0, 0, "clean_a");
        m = '0; m[20] = 1'b1;
        run_word(wb, m, 0, '0, 0, "late_error_skipped");
        m = '0; m[72] = 1'b1;
        run_word(wa, m, 0, '0, 0, "err_cycle1");
        m = '0; m[70] = 1'b1; m[40] = 1'b1; m[10] = 1'b1;
        run_word(wb, m, 0, '0, 0, "err_cycle3_three");
        m = '0; m[71] = 1'b1; m[60] = 1'b1; m[33] = 1'b1; m[0] = 1'b1;
        run_word(wa, m, 0, '0, 0, "four_err_last_cycle");
        run_word(wb, '0, 2, 9'b000001111, 0, "R6 weight4_no_flip");
        run_word(wa, '0, 3, 9'b000011111, 0, "R6 weight5_flip");
        m = '0; m[15] = 1'b1;
        run_word(wb, m, 1, 9'b000000001, 20, "R2 stray_start");
        run_word(wb, '0, 0, '0, 0, "R10 clean_after_full");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule